// File: doc/BRIEF.md
# Keyed Warm-Reboot Controller

This block lets software ask the FPGA configuration logic to warm-boot into one of four stored images. Software writes one 8-bit control byte. The upper six bits of that byte must carry a fixed unlock key, and the lower two bits name the target image. When the key matches, the block latches the image number onto an image-select output and raises a one-cycle boot pulse. The configuration primitive samples both. When the key does not match, the write is dropped, so a stray store into this address range cannot restart the device.

The block also holds a 32-bit CPU reset vector. Software loads it through four byte-wide registers, and the CPU picks it up on every reset, including resets issued from a debug bridge. The vector is driven continuously on an output port. The bus side is a plain byte-wide write strobe and read strobe with a small address. The internal reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `warmboot_ctrl`

## Requirements
- R1: Byte address 0 is the control byte. Bits [7:2] are the key and bits [1:0] are the image number. A write to address 0 is accepted only when bits [7:2] equal binary 101011.
- R2: An accepted write raises `boot_pulse` for exactly one cycle, in the cycle that follows the write. No other write raises it.
- R3: An accepted write sets `boot_image` to bits [1:0] of the written byte, from the same cycle as the pulse. The value then holds until the next accepted write.
- R4: A write to address 0 with any other key produces no pulse, leaves `boot_image` unchanged and leaves the control readback unchanged.
- R5: Writing 0xAC selects image 0, the bootloader. Writing 0xAF selects image 3.
- R6: Addresses 1, 2, 3 and 4 hold reset-vector bits 31:24, 23:16, 15:8 and 7:0, in that order. A write updates its byte on `reset_vector` in the next cycle and leaves the other three bytes unchanged.
- R7: After reset, `boot_image`, `boot_pulse` and `reset_vector` are zero, and every register reads back as zero.
- R8: While `rd_en` is high, `rd_data` combinationally returns the last accepted control byte at address 0 and the matching vector byte at addresses 1 to 4. `rd_data` is zero when `rd_en` is low or the address is 5 to 7.
- R9: Writes to addresses 5 to 7 change no output and no readable state.
- R10: Control writes, accepted or rejected, never change `reset_vector`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| boot_image | output | 2 | Latched image selection for the configuration logic |
| boot_pulse | output | 1 | One-cycle request to warm-boot |
| reset_vector | output | 32 | CPU reset vector |

## Verification
The checker evaluates these properties on every cycle:
- a boot pulse appears exactly when a keyed control write happened one cycle earlier;
- the latched image matches that write;
- a wrong-key write leaves the image untouched;
- each vector byte follows a write to its own address and stays steady otherwise.

Some behaviour shows up only in the bench's scenarios: the combinational readback values, the two documented example bytes, and the zero state of the outputs after reset. Unmapped-address writes also belong here, because their effect is only visible by reading every register back afterwards.

// File: rtl/warmboot_pkg.sv
package warmboot_pkg;
  localparam int BYTE_W    = 8;
  localparam int CTRL_ADDR = 0;
  localparam int VEC_BASE  = 1;
endpackage

// File: rtl/warmboot_rst_sync.sv
module warmboot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/warmboot_key_gate.sv
module warmboot_key_gate
  import warmboot_pkg::*;
#(
  parameter int          ADDR_W    = 3,
  parameter int          IMG_W     = 2,
  parameter int          VEC_BYTES = 4,
  parameter logic [BYTE_W-IMG_W-1:0] KEY = 6'b101011
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BYTE_W-1:0]    wr_data,
  output logic                 boot_accept,
  output logic [VEC_BYTES-1:0] vec_we
);
  logic ctrl_sel;
  logic key_match;

  assign ctrl_sel    = (addr == ADDR_W'(CTRL_ADDR));
  assign key_match   = (wr_data[BYTE_W-1:IMG_W] == KEY);
  assign boot_accept = wr_en & ctrl_sel & key_match;

  // one write enable per vector byte; lowest address carries the top byte
  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_vec_we
    assign vec_we[g] = wr_en & (addr == ADDR_W'(VEC_BASE + g));
  end
endmodule

// File: rtl/warmboot_vec_regs.sv
module warmboot_vec_regs
  import warmboot_pkg::*;
#(
  parameter int VEC_BYTES = 4,
  localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [VEC_BYTES-1:0] vec_we,
  input  logic [BYTE_W-1:0]    wr_data,
  output logic [VEC_W-1:0]     vec_q
);
  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_byte
    localparam int LSB = (VEC_BYTES - 1 - g) * BYTE_W;
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;

    always_comb begin
      byte_d = byte_q;
      if (vec_we[g]) byte_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         byte_q <= '0;
      else if (vec_we[g]) byte_q <= byte_d;
    end

    assign vec_q[LSB +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/warmboot_boot_seq.sv
module warmboot_boot_seq
  import warmboot_pkg::*;
#(
  parameter int IMG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_accept,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [IMG_W-1:0]  image_q,
  output logic              pulse_q
);
  logic [BYTE_W-1:0] ctrl_d;
  logic [IMG_W-1:0]  image_d;
  logic              pulse_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    image_d = image_q;
    pulse_d = boot_accept;
    if (boot_accept) begin
      ctrl_d  = wr_data;
      image_d = wr_data[IMG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      image_q <= '0;
    end else if (boot_accept) begin
      ctrl_q  <= ctrl_d;
      image_q <= image_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end
endmodule

// File: rtl/warmboot_ctrl.sv
module warmboot_ctrl
  import warmboot_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int IMG_W     = 2,
  parameter int VEC_BYTES = 4,
  parameter logic [BYTE_W-IMG_W-1:0] KEY = 6'b101011,
  localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic [IMG_W-1:0]  boot_image,
  output logic              boot_pulse,
  output logic [VEC_W-1:0]  reset_vector
);
  logic                 rst_sync_n;
  logic                 boot_accept;
  logic [VEC_BYTES-1:0] vec_we;
  logic [BYTE_W-1:0]    ctrl_q;
  logic [VEC_W-1:0]     vec_q;

  warmboot_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  warmboot_key_gate #(
    .ADDR_W    (ADDR_W),
    .IMG_W     (IMG_W),
    .VEC_BYTES (VEC_BYTES),
    .KEY       (KEY)
  ) key_gate_i (
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .boot_accept (boot_accept),
    .vec_we      (vec_we)
  );

  warmboot_vec_regs #(.VEC_BYTES(VEC_BYTES)) vec_regs_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .vec_we  (vec_we),
    .wr_data (wr_data),
    .vec_q   (vec_q)
  );

  warmboot_boot_seq #(.IMG_W(IMG_W)) boot_seq_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .boot_accept (boot_accept),
    .wr_data     (wr_data),
    .ctrl_q      (ctrl_q),
    .image_q     (boot_image),
    .pulse_q     (boot_pulse)
  );

  assign reset_vector = vec_q;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (addr == ADDR_W'(CTRL_ADDR)) rd_data = ctrl_q;
      for (int i = 0; i < VEC_BYTES; i++) begin
        if (addr == ADDR_W'(VEC_BASE + i))
          rd_data = vec_q[(VEC_BYTES - 1 - i) * BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/warmboot_ctrl_chk.sv
module warmboot_ctrl_chk
  import warmboot_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int IMG_W     = 2,
  parameter int VEC_BYTES = 4,
  parameter logic [BYTE_W-IMG_W-1:0] KEY = 6'b101011,
  localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic [IMG_W-1:0]  boot_image,
  input logic              boot_pulse,
  input logic [VEC_W-1:0]  reset_vector
);
  logic ctrl_wr;
  logic good_key;
  assign ctrl_wr  = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign good_key = (wr_data[BYTE_W-1:IMG_W] == KEY);

  // R2: pulse follows a keyed control write by one cycle, and nothing else
  assert_pulse_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    boot_pulse == $past(ctrl_wr && good_key));

  // R3: image carries the accepted byte's low bits
  assert_image_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && good_key) |=> boot_image == $past(wr_data[IMG_W-1:0]));

  // R4: wrong key keeps the image and gives no pulse
  assert_bad_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !good_key) |=> ($stable(boot_image) && !boot_pulse));

  // R10: control writes never disturb the vector
  assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> $stable(reset_vector));

  // R7: outputs are zero when the internal reset is released
  assert_reset_zero_R7: assert property (@(posedge clk)
    $rose(rst_n) |-> (reset_vector == '0 && boot_image == '0 && !boot_pulse));

  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_vec_chk
    localparam int LSB = (VEC_BYTES - 1 - g) * BYTE_W;
    // R6: byte follows its own address and holds otherwise
    assert_vec_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(VEC_BASE + g)) |=>
        reset_vector[LSB +: BYTE_W] == $past(wr_data));
    assert_vec_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(VEC_BASE + g)) |=>
        $stable(reset_vector[LSB +: BYTE_W]));
  end
endmodule

bind warmboot_ctrl warmboot_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .IMG_W     (IMG_W),
  .VEC_BYTES (VEC_BYTES),
  .KEY       (KEY)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .wr_en        (wr_en),
  .addr         (addr),
  .wr_data      (wr_data),
  .boot_image   (boot_image),
  .boot_pulse   (boot_pulse),
  .reset_vector (reset_vector)
);

// File: tb/warmboot_ctrl_tb.sv
`timescale 1ns/1ps
module warmboot_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [1:0]  boot_image;
  logic        boot_pulse;
  logic [31:0] reset_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  exp_ctrl = '0;
  logic [1:0]  exp_img  = '0;
  logic [31:0] exp_vec  = '0;

  always #2 clk = ~clk;

  warmboot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .boot_image(boot_image),
    .boot_pulse(boot_pulse), .reset_vector(reset_vector)
  );

  function automatic bit key_ok(input logic [7:0] d);
    return d[7:2] == 6'b101011;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return exp_ctrl;
      3'd1: return exp_vec[31:24];
      3'd2: return exp_vec[23:16];
      3'd3: return exp_vec[15:8];
      3'd4: return exp_vec[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // write one byte, then check pulse, image and vector in the following cycle
  task automatic do_write(input logic [2:0] a, input logic [7:0] d, input string req);
    bit accept;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    accept = (a == 3'd0) && key_ok(d);
    if (accept) begin exp_ctrl = d; exp_img = d[1:0]; end
    case (a)
      3'd1: exp_vec[31:24] = d;
      3'd2: exp_vec[23:16] = d;
      3'd3: exp_vec[15:8]  = d;
      3'd4: exp_vec[7:0]   = d;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
    check(boot_pulse == accept, {req, " R2 pulse"}, 32'(boot_pulse), 32'(accept));
    check(boot_image == exp_img, {req, " R3 image"}, 32'(boot_image), 32'(exp_img));
    check(reset_vector == exp_vec, {req, " R6/R10 vector"}, reset_vector, exp_vec);
    @(negedge clk);
    check(boot_pulse == 1'b0, {req, " R2 single cycle"}, 32'(boot_pulse), 32'd0);
  endtask

  task automatic do_read(input logic [2:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1;
    e = exp_read(a);
    check(rd_data == e, {req, " R8 read"}, 32'(rd_data), 32'(e));
    rd_en = 1'b0;
    #1;
    check(rd_data == 8'h00, {req, " R8 idle read"}, 32'(rd_data), 32'd0);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 8; a++) do_read(3'(a), req);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: reset state
    check(boot_image == 2'd0, "R7 image", 32'(boot_image), 0);
    check(boot_pulse == 1'b0, "R7 pulse", 32'(boot_pulse), 0);
    check(reset_vector == 32'd0, "R7 vector", reset_vector, 0);
    read_all("R7");

    // R5: documented example values
    do_write(3'd0, 8'hAF, "R5 image3");
    do_write(3'd0, 8'hAC, "R5 image0");
    do_read(3'd0, "R5");

    // R1/R4: wrong keys, including single-bit key flips
    do_write(3'd0, 8'hAE, "R1 setup");
    for (int b = 2; b < 8; b++) do_write(3'd0, 8'hAD ^ (8'd1 << b), "R4 keyflip");
    do_write(3'd0, 8'h03, "R4 zero key");
    do_read(3'd0, "R4");

    // R6: byte order of the reset vector
    do_write(3'd1, 8'h12, "R6 b3");
    do_write(3'd2, 8'h34, "R6 b2");
    do_write(3'd3, 8'h56, "R6 b1");
    do_write(3'd4, 8'h78, "R6 b0");
    check(reset_vector == 32'h12345678, "R6 order", reset_vector, 32'h12345678);
    read_all("R6");

    // R9: unmapped writes
    for (int a = 5; a < 8; a++) do_write(3'(a), 8'hFF, "R9 unmapped");
    read_all("R9");

    // R10: boot does not disturb vector
    do_write(3'd0, 8'hAD, "R10 boot");
    check(reset_vector == 32'h12345678, "R10 vector kept", reset_vector, 32'h12345678);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom());
      if (a == 3'd0 && $urandom_range(0, 1) == 1) d[7:2] = 6'b101011;
      do_write(a, d, "R1 random");
      if ($urandom_range(0, 3) == 0) do_read(3'($urandom_range(0, 7)), "R8 random");
    end
    read_all("R8 final");

    // back-to-back accepted writes: one pulse per write
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wr_data = 8'hAD;
    @(negedge clk);
    wr_data = 8'hAE;
    check(boot_pulse && boot_image == 2'd1, "R2 b2b first", 32'(boot_image), 1);
    @(negedge clk);
    wr_en = 1'b0;
    check(boot_pulse && boot_image == 2'd2, "R3 b2b second", 32'(boot_image), 2);
    exp_ctrl = 8'hAE; exp_img = 2'd2;
    @(negedge clk);
    check(!boot_pulse, "R2 b2b end", 32'(boot_pulse), 0);

    // R7: reset in mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_ctrl = '0; exp_img = '0; exp_vec = '0;
    repeat (3) @(negedge clk);
    check(reset_vector == 32'd0 && boot_image == 2'd0, "R7 rerun", reset_vector, 0);
    read_all("R7 rerun");

    finish_run();
  end
endmodule